// File: doc/BRIEF.md
# ADC Conversion Sequencer and Result Formatter

This block is the digital control wrapped around a 10-bit successive-approximation converter. A 3-bit start-mode input picks one of six start sources: a software write strobe, four timer overflow pulses, or a rising edge on an asynchronous convert-start pin. Once a start is accepted, the block runs a conversion of fixed length. The conversion is paced by a tick derived from the system clock through a programmable divider. The block raises a busy flag for the whole conversion.

At the end of the conversion, the raw code on the input port is captured. It is formatted as an unsigned (single-ended) or two's-complement (differential) value, placed right- or left-justified in a 16-bit word, and latched into the result register. A one-cycle done pulse marks the update. The analog front end is not part of the block: the `raw_code` port stands in for the comparator output.

The control is a four-state machine, with its transitions named below:
- `ST_IDLE` moves to `ST_TRACK` on an accepted start request (transition "launch").
- `ST_TRACK` moves to `ST_CONV` after one tick (transition "hold").
- `ST_CONV` moves to `ST_FINISH` after ten ticks, one per bit (transition "bits_done").
- `ST_FINISH` moves back to `ST_IDLE` after two ticks (transition "complete"). The result is latched on this transition.

Top module: `adc_seq_fmt`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0x0000.
- R2: `start_mode` selects the only start source that is honoured: 0 = `sw_start` strobe, 1 = `tmr0_ovf`, 2 = `tmr2_ovf`, 3 = `tmr1_ovf`, 4 = rising edge of `ext_start`, 5 = `tmr3_ovf`. Values 6 and 7 start nothing. Pulses on any unselected source leave `busy` at 0.
- R3: `ext_start` passes through a two-flop synchronizer before edge detection. A level held high starts exactly one conversion.
- R4: `busy` stays high for exactly 13 × (`cfg_div` + 1) system-clock cycles per conversion (1 track tick, 10 bit ticks, 2 finish ticks). Each tick lasts `cfg_div` + 1 cycles.
- R5: `done` is high for exactly one cycle, in the same cycle that `busy` first reads 0 and `result` shows the new word. `result` keeps its value until the next `done`.
- R6: Start requests that arrive while `busy` is high are ignored. They neither extend nor restart the conversion.
- R7: Single-ended, right-justified: `result` = {6'b0, code}. For example, 0x3FF gives 0x03FF.
- R8: Differential, right-justified: bits 15:10 copy code bit 9. For example, 0x200 gives 0xFE00 and 0x1FF gives 0x01FF.
- R9: Left-justified, in either mode: the code occupies bits 15:6 and bits 5:0 are 0. For example, 0x3FF gives 0xFFC0 and 0x200 gives 0x8000.
- R10: Changing `diff_mode` or `left_just` after `done` leaves the latched `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Divider setting; one conversion tick every cfg_div+1 cycles |
| start_mode | input | 3 | Start-source select |
| sw_start | input | 1 | Software start strobe (write of 1 to busy) |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tmr3_ovf | input | 1 | Timer 3 overflow pulse |
| ext_start | input | 1 | Asynchronous convert-start pin |
| diff_mode | input | 1 | 1 = differential (signed) coding |
| left_just | input | 1 | 1 = left-justified result |
| raw_code | input | CODE_W | Converter output code |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result-update pulse |
| result | output | OUT_W | Formatted result word |

## Verification
The bench builds the block with DIV_W = 3, keeping CODE_W = 10 and OUT_W = 16. The narrow divider puts its all-ones setting (7, so 104-cycle conversions) within reach, next to the undivided setting 0 and the middle setting 2. Each busy window length is therefore checked at the minimum, a middle value and the maximum. The fixed 10-in-16 word widths let every sign-extension and justification corner (full scale, most negative, mid codes) be compared against hand-computed words.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRACK,
        ST_CONV,
        ST_FINISH
    } conv_state_e;

    localparam logic [2:0] SRC_SW   = 3'd0;
    localparam logic [2:0] SRC_TMR0 = 3'd1;
    localparam logic [2:0] SRC_TMR2 = 3'd2;
    localparam logic [2:0] SRC_TMR1 = 3'd3;
    localparam logic [2:0] SRC_EXT  = 3'd4;
    localparam logic [2:0] SRC_TMR3 = 3'd5;

    localparam int TRACK_TICKS  = 1;
    localparam int FINISH_TICKS = 2;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] start_mode,
    input  logic       sw_start,
    input  logic       tmr0_ovf,
    input  logic       tmr1_ovf,
    input  logic       tmr2_ovf,
    input  logic       tmr3_ovf,
    input  logic       ext_start,
    output logic       start_req
);

    logic [2:0] ext_q;
    logic       ext_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= {ext_q[1:0], ext_start};
    end

    assign ext_rise = ext_q[1] & ~ext_q[2];

    always_comb begin
        unique case (start_mode)
            SRC_SW:   start_req = sw_start;
            SRC_TMR0: start_req = tmr0_ovf;
            SRC_TMR2: start_req = tmr2_ovf;
            SRC_TMR1: start_req = tmr1_ovf;
            SRC_EXT:  start_req = ext_rise;
            SRC_TMR3: start_req = tmr3_ovf;
            default:  start_req = 1'b0;
        endcase
    end

    // R3: an edge request needs the pin low then high on the synchronized path
    p_ext_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_mode == SRC_EXT && start_req) |=> (ext_q[2] && !$past(ext_q[2])));

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)  cnt <= '0;
        else if (cnt == div)  cnt <= '0;
        else                  cnt <= cnt + DIV_W'(1);
    end

    assign tick = !clear && (cnt == div);

    // R4: the prescaler restarts from zero after every tick
    p_tick_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

endmodule

// File: rtl/adc_fmt.sv
module adc_fmt #(
    parameter int CODE_W = 10,
    parameter int OUT_W  = 16
) (
    input  logic [CODE_W-1:0] code,
    input  logic              diff_mode,
    input  logic              left_just,
    output logic [OUT_W-1:0]  word
);

    localparam int PAD_W = OUT_W - CODE_W;

    logic [PAD_W-1:0] pad_hi;

    generate
        if (PAD_W > 0) begin : g_pad
            assign pad_hi = {PAD_W{diff_mode & code[CODE_W-1]}};
        end
    endgenerate

    always_comb begin
        if (left_just) word = {code, {PAD_W{1'b0}}};
        else           word = {pad_hi, code};
    end

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt
    import adc_seq_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int OUT_W  = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [2:0]        start_mode,
    input  logic              sw_start,
    input  logic              tmr0_ovf,
    input  logic              tmr1_ovf,
    input  logic              tmr2_ovf,
    input  logic              tmr3_ovf,
    input  logic              ext_start,
    input  logic              diff_mode,
    input  logic              left_just,
    input  logic [CODE_W-1:0] raw_code,
    output logic              busy,
    output logic              done,
    output logic [OUT_W-1:0]  result
);

    localparam int              CNT_W     = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] LAST_TRK = CNT_W'(TRACK_TICKS - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);
    localparam logic [CNT_W-1:0] LAST_FIN = CNT_W'(FINISH_TICKS - 1);

    conv_state_e      state, state_nx;
    logic [CNT_W-1:0] phase_cnt;
    logic             start_req;
    logic             tick;
    logic             finishing;
    logic [OUT_W-1:0] fmt_word;

    adc_trig_sel u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_mode(start_mode),
        .sw_start  (sw_start),
        .tmr0_ovf  (tmr0_ovf),
        .tmr1_ovf  (tmr1_ovf),
        .tmr2_ovf  (tmr2_ovf),
        .tmr3_ovf  (tmr3_ovf),
        .ext_start (ext_start),
        .start_req (start_req)
    );

    adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(state == ST_IDLE),
        .div  (cfg_div),
        .tick (tick)
    );

    adc_fmt #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_fmt (
        .code     (raw_code),
        .diff_mode(diff_mode),
        .left_just(left_just),
        .word     (fmt_word)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_req)                        state_nx = ST_TRACK;  // launch
            ST_TRACK:  if (tick && phase_cnt == LAST_TRK)    state_nx = ST_CONV;   // hold
            ST_CONV:   if (tick && phase_cnt == LAST_BIT)    state_nx = ST_FINISH; // bits_done
            ST_FINISH: if (tick && phase_cnt == LAST_FIN)    state_nx = ST_IDLE;   // complete
            default:                                         state_nx = ST_IDLE;
        endcase
    end

    assign finishing = (state == ST_FINISH) && (state_nx == ST_IDLE);

    // state register and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) phase_cnt <= '0;
            else if (tick)         phase_cnt <= phase_cnt + CNT_W'(1);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= finishing;
            if (finishing) result <= fmt_word;
        end
    end

    assign busy = (state != ST_IDLE);

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: done coincides with the end of busy
    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10: the result word only moves with done
    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R6: busy only rises after an accepted start request
    p_busy_from_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_req));

    // R9: left-justified words have clear low bits
    p_left_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (finishing && left_just) |=> (result[OUT_W-CODE_W-1:0] == '0));

endmodule

// File: tb/test_adc_seq_fmt.sv
module test_adc_seq_fmt;

    localparam int TB_DIV_W = 3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [TB_DIV_W-1:0] cfg_div = '0;
    logic [2:0]          start_mode = '0;
    logic                sw_start = 0, tmr0_ovf = 0, tmr1_ovf = 0, tmr2_ovf = 0, tmr3_ovf = 0;
    logic                ext_start = 0, diff_mode = 0, left_just = 0;
    logic [9:0]          raw_code = '0;
    logic                busy, done;
    logic [15:0]         result;

    typedef struct packed {
        logic [15:0] word;
        int          len;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   busy_cnt = 0;

    always #2.5 clk = ~clk;

    adc_seq_fmt #(.CODE_W(10), .OUT_W(16), .DIV_W(TB_DIV_W)) i_adc_seq_fmt (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .start_mode(start_mode),
        .sw_start(sw_start), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .tmr2_ovf(tmr2_ovf), .tmr3_ovf(tmr3_ovf), .ext_start(ext_start),
        .diff_mode(diff_mode), .left_just(left_just), .raw_code(raw_code),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_word(input logic [9:0] c, input logic d, input logic l);
        if (l)      return {c, 6'b000000};
        else if (d) return {{6{c[9]}}, c};
        else        return {6'b000000, c};
    endfunction

    // monitor: counts busy cycles and compares each completed result
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt <= busy_cnt + 1;
            if (done) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(result == e.word, "R7/R8/R9 result word", int'(result), int'(e.word));
                    chk(busy_cnt == e.len, "R4 busy length", busy_cnt, e.len);
                    chk(busy == 1'b0, "R5 busy low with done", int'(busy), 0);
                end
                busy_cnt <= 0;
            end
        end
    end

    task automatic pulse_src(input logic [2:0] m);
        @(negedge clk);
        case (m)
            3'd0: sw_start = 1;
            3'd1: tmr0_ovf = 1;
            3'd2: tmr2_ovf = 1;
            3'd3: tmr1_ovf = 1;
            3'd4: ext_start = 1;
            3'd5: tmr3_ovf = 1;
            default: ;
        endcase
        @(negedge clk);
        {sw_start, tmr0_ovf, tmr1_ovf, tmr2_ovf, tmr3_ovf} = '0;
    endtask

    // driver: configures, pushes the expectation, fires the start and waits
    task automatic run_conv(input logic [2:0] m, input logic [9:0] c, input logic d,
                            input logic l, input logic [TB_DIV_W-1:0] dv);
        exp_t e;
        @(negedge clk);
        start_mode = m; raw_code = c; diff_mode = d; left_just = l; cfg_div = dv;
        e.word = expect_word(c, d, l);
        e.len  = 13 * (int'(dv) + 1);
        q.push_back(e);
        pulse_src(m);
        while (q.size() != 0) @(negedge clk);
        if (m == 3'd4) begin
            repeat (6) @(negedge clk);
            chk(busy == 1'b0, "R3 held pin no restart", int'(busy), 0);
            ext_start = 0;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0, "R1 busy reset", int'(busy), 0);
        chk(done == 0, "R1 done reset", int'(done), 0);
        chk(result == 16'h0000, "R1 result reset", int'(result), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 each source in its own mode; R7 R8 R9 formats
        run_conv(3'd0, 10'h3FF, 0, 0, 3'd0);   // R7 0x03FF
        run_conv(3'd1, 10'h200, 0, 0, 3'd2);   // R7 0x0200
        run_conv(3'd2, 10'h200, 1, 0, 3'd7);   // R8 0xFE00
        run_conv(3'd3, 10'h1FF, 1, 0, 3'd1);   // R8 0x01FF
        run_conv(3'd4, 10'h100, 1, 0, 3'd0);   // R8 0x0100, R3 edge
        run_conv(3'd5, 10'h3FF, 0, 1, 3'd2);   // R9 0xFFC0
        run_conv(3'd0, 10'h200, 1, 1, 3'd0);   // R9 0x8000
        run_conv(3'd1, 10'h100, 0, 1, 3'd3);   // R9 0x4000

        // R10: reformat bits changed after done
        @(negedge clk);
        diff_mode = 0; left_just = 0;
        repeat (4) @(negedge clk);
        chk(result == 16'h4000, "R10 latched word kept", int'(result), 16'h4000);

        // R2: unselected sources ignored in mode 1
        start_mode = 3'd1;
        pulse_src(3'd0); pulse_src(3'd2); pulse_src(3'd3); pulse_src(3'd5);
        repeat (2) @(negedge clk);
        chk(busy == 0, "R2 unselected ignored", int'(busy), 0);

        // R2: modes 6 and 7 start nothing
        for (int m = 6; m < 8; m++) begin
            start_mode = 3'(m);
            pulse_src(3'd0); pulse_src(3'd1); pulse_src(3'd2);
            pulse_src(3'd3); pulse_src(3'd5);
            repeat (2) @(negedge clk);
            chk(busy == 0, "R2 reserved mode idle", int'(busy), 0);
        end

        // R6: retrigger while busy is ignored
        begin
            exp_t e;
            start_mode = 3'd0; raw_code = 10'h155; cfg_div = 3'd1;
            e.word = expect_word(10'h155, 0, 0); e.len = 26;
            q.push_back(e);
            pulse_src(3'd0);
            repeat (10) @(negedge clk);
            pulse_src(3'd0);
            repeat (8) @(negedge clk);
            pulse_src(3'd0);
            while (q.size() != 0) @(negedge clk);
            repeat (4) @(negedge clk);
            chk(busy == 0, "R6 no restart after busy", int'(busy), 0);
            chk(result == 16'h0155, "R5 result holds", int'(result), 16'h0155);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R4 watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule